// File: doc/BRIEF.md
# APB Hang-Guard Bridge

This block sits between one APB manager and several APB subordinates. It turns the upper address bits into a one-hot select per subordinate, forwards the shared request signals, and merges the subordinates' ready, read-data and error returns into one response for the manager. Its main job is to keep the shared bus from being stuck behind a subordinate that never answers.

Three mechanisms provide that guarantee. First, only the selected subordinate's ready is taken into account, and the bridge reports ready whenever no access is in progress. Second, an address with no subordinate behind it, or one whose subordinate's clock is reported as off, is answered at once by the bridge with an error. Third, a cycle-limit watchdog ends any access that stays not-ready for too long and reports it as an ordinary slave error. A sticky status bit records the first such abort and its address until software clears it through a dedicated input.

Subordinate `i` owns the address window whose bits `[AW-1:RB]` equal `i`. Index values at or above `NS` are unmapped. Error-region and timeout completions return all-zero read data.

Top module: `apb_guard_bridge`

## Requirements
- R1: For an access to a mapped, clocked subordinate `i` (address bits `[AW-1:RB]` equal to `i`), only `s_psel[i]` is high, and address, write data, direction and enable are forwarded unchanged. `s_psel` never has more than one bit set.
- R2: For a normal access, the manager sees the selected subordinate's ready, read data and error, so an access with N wait cycles completes after exactly N wait cycles with that subordinate's data and error flag.
- R3: The ready of a non-selected subordinate has no effect. While `m_psel` is low, `m_pready` is high, `m_pslverr` is low and `m_prdata` is zero.
- R4: An access whose index is `NS` or above selects no subordinate and completes in its first access cycle with `m_pslverr` high and `m_prdata` zero.
- R5: An access to a subordinate whose `s_clk_on` bit is low is handled like R4: no select, zero waits, error, zero data.
- R6: When the selected subordinate stays not-ready, the bridge completes the access on its `LIMIT`-th access cycle (`LIMIT-1` wait cycles), with `m_pslverr` high and `m_prdata` zero.
- R7: The wait counter runs only while an access to a valid target waits, and it clears otherwise. A subordinate that becomes ready on the `LIMIT`-th access cycle completes normally, without a timeout error.
- R8: After an aborted access, the next access to any subordinate completes normally.
- R9: An abort sets `to_flag`, which then stays set until `to_clear` is pulsed. A clear on its own zeroes both `to_flag` and `to_addr`. If an abort and a clear fall in the same cycle, the flag ends up set and the address of that abort is captured.
- R10: `to_addr` holds the address of the abort that set the flag. Later aborts do not overwrite it while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_psel | input | 1 | Manager select |
| m_penable | input | 1 | Manager enable (access phase) |
| m_pwrite | input | 1 | Manager direction, 1 = write |
| m_paddr | input | AW | Manager address |
| m_pwdata | input | DW | Manager write data |
| m_prdata | output | DW | Read data returned to the manager |
| m_pready | output | 1 | Completion returned to the manager |
| m_pslverr | output | 1 | Error returned to the manager |
| s_psel | output | NS | One-hot subordinate selects |
| s_penable | output | 1 | Forwarded enable |
| s_pwrite | output | 1 | Forwarded direction |
| s_paddr | output | AW | Forwarded address |
| s_pwdata | output | DW | Forwarded write data |
| s_prdata | input | NS*DW | Read data of all subordinates, subordinate i in bits [i*DW +: DW] |
| s_pready | input | NS | Ready of each subordinate |
| s_pslverr | input | NS | Error of each subordinate |
| s_clk_on | input | NS | 1 = subordinate clock running, 0 = gated off |
| to_clear | input | 1 | Clears the sticky timeout status |
| to_flag | output | 1 | Sticky timeout status |
| to_addr | output | AW | Address of the captured aborted access |

## Verification
Two functions can fall in the same cycle: the watchdog abort and the software clear of the sticky status. The bench waits in the driver until the cycle where the bridge force-completes a hung access, raises `to_clear` in that same cycle, and then expects the flag to be still set and the address to be that of the new abort. A second collision is a subordinate that becomes ready on exactly the cycle the watchdog would fire. That case must be judged as a normal completion with the subordinate's own data, with no error and no sticky update.

// File: rtl/apb_guard_pkg.sv
`timescale 1ns/1ps
package apb_guard_pkg;

    // Classification of the current request by the address decoder.
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,   // no request on the bus
        CLS_TARGET = 2'd1,   // mapped and clocked subordinate
        CLS_HOLE   = 2'd2,   // no subordinate at this address
        CLS_GATED  = 2'd3    // subordinate present but clock is off
    } dec_class_e;

    function automatic logic is_err_region(dec_class_e c);
        return (c == CLS_HOLE) || (c == CLS_GATED);
    endfunction

endpackage

// File: rtl/apb_guard_decode.sv
`timescale 1ns/1ps
module apb_guard_decode
    import apb_guard_pkg::*;
#(
    parameter int NS = 4,
    parameter int IW = 4
) (
    input  logic          psel,
    input  logic [IW-1:0] region,
    input  logic [NS-1:0] clk_on,
    output logic [NS-1:0] sel,
    output dec_class_e    cls
);

    logic [NS-1:0] match;

    generate
        for (genvar i = 0; i < NS; i++) begin : g_match
            assign match[i] = (region == IW'(i));
        end
    endgenerate

    always_comb begin
        cls = CLS_NONE;
        if (psel) begin
            if (!(|match)) begin
                cls = CLS_HOLE;
            end else if (!(|(match & clk_on))) begin
                cls = CLS_GATED;
            end else begin
                cls = CLS_TARGET;
            end
        end
    end

    assign sel = match & clk_on & {NS{psel}};

endmodule

// File: rtl/apb_guard_retmux.sv
`timescale 1ns/1ps
module apb_guard_retmux #(
    parameter int NS = 4,
    parameter int DW = 32
) (
    input  logic [NS-1:0]    sel,
    input  logic [NS*DW-1:0] rdata_all,
    input  logic [NS-1:0]    ready_all,
    input  logic [NS-1:0]    err_all,
    output logic             ready,
    output logic             err,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] masked [NS];

    generate
        for (genvar i = 0; i < NS; i++) begin : g_mask
            assign masked[i] = rdata_all[i*DW +: DW] & {DW{sel[i]}};
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NS; i++) begin
            rdata = rdata | masked[i];
        end
    end

    // Only the selected port contributes; others are effectively ready.
    assign ready = |(sel & ready_all);
    assign err   = |(sel & err_all);

endmodule

// File: rtl/apb_guard_watchdog.sv
`timescale 1ns/1ps
module apb_guard_watchdog #(
    parameter int LIMIT = 1024,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,   // access phase toward a valid target
    input  logic          ready,    // selected subordinate ready
    output logic          fire,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_state_t;

    wd_state_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        fire = 1'b0;
        if (active && !ready) begin
            if (wd_q.cnt == LAST) begin
                fire     = 1'b1;
                wd_d.cnt = LAST;          // saturate, never wrap
            end else begin
                wd_d.cnt = wd_q.cnt + 1'b1;
            end
        end else begin
            wd_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign cnt = wd_q.cnt;

endmodule

// File: rtl/apb_guard_bridge.sv
`timescale 1ns/1ps
module apb_guard_bridge
    import apb_guard_pkg::*;
#(
    parameter int NS    = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int RB    = 12,
    parameter int LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_psel,
    input  logic             m_penable,
    input  logic             m_pwrite,
    input  logic [AW-1:0]    m_paddr,
    input  logic [DW-1:0]    m_pwdata,
    output logic [DW-1:0]    m_prdata,
    output logic             m_pready,
    output logic             m_pslverr,
    output logic [NS-1:0]    s_psel,
    output logic             s_penable,
    output logic             s_pwrite,
    output logic [AW-1:0]    s_paddr,
    output logic [DW-1:0]    s_pwdata,
    input  logic [NS*DW-1:0] s_prdata,
    input  logic [NS-1:0]    s_pready,
    input  logic [NS-1:0]    s_pslverr,
    input  logic [NS-1:0]    s_clk_on,
    input  logic             to_clear,
    output logic             to_flag,
    output logic [AW-1:0]    to_addr
);

    localparam int IW = AW - RB;
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic          flag;
        logic [AW-1:0] addr;
    } sticky_t;

    dec_class_e    dec_cls;
    logic [NS-1:0] dec_sel;
    logic          sel_ready;
    logic          sel_err;
    logic [DW-1:0] sel_rdata;
    logic          acc_phase;
    logic          tgt_active;
    logic          wd_fire;
    logic [CW-1:0] wd_cnt;
    sticky_t       st_d, st_q;

    apb_guard_decode #(
        .NS (NS),
        .IW (IW)
    ) u_decode (
        .psel   (m_psel),
        .region (m_paddr[AW-1:RB]),
        .clk_on (s_clk_on),
        .sel    (dec_sel),
        .cls    (dec_cls)
    );

    apb_guard_retmux #(
        .NS (NS),
        .DW (DW)
    ) u_retmux (
        .sel       (dec_sel),
        .rdata_all (s_prdata),
        .ready_all (s_pready),
        .err_all   (s_pslverr),
        .ready     (sel_ready),
        .err       (sel_err),
        .rdata     (sel_rdata)
    );

    assign acc_phase  = m_psel && m_penable;
    assign tgt_active = acc_phase && (dec_cls == CLS_TARGET);

    apb_guard_watchdog #(
        .LIMIT (LIMIT),
        .CW    (CW)
    ) u_watchdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (tgt_active),
        .ready  (sel_ready),
        .fire   (wd_fire),
        .cnt    (wd_cnt)
    );

    // Request forwarding
    assign s_psel    = dec_sel;
    assign s_penable = m_penable;
    assign s_pwrite  = m_pwrite;
    assign s_paddr   = m_paddr;
    assign s_pwdata  = m_pwdata;

    // Response toward the manager
    always_comb begin
        m_pready  = 1'b1;
        m_pslverr = 1'b0;
        m_prdata  = '0;
        if (dec_cls == CLS_TARGET) begin
            m_pready = sel_ready | wd_fire;
            if (acc_phase) begin
                m_pslverr = wd_fire ? 1'b1 : sel_err;
                m_prdata  = wd_fire ? '0 : sel_rdata;
            end
        end else if (is_err_region(dec_cls)) begin
            m_pready  = 1'b1;
            m_pslverr = acc_phase;
        end
    end

    // Sticky abort status: next-state
    always_comb begin
        st_d = st_q;
        if (to_clear) begin
            st_d.flag = 1'b0;
            st_d.addr = '0;
        end
        if (wd_fire) begin
            st_d.flag = 1'b1;
            if (!st_q.flag || to_clear) begin
                st_d.addr = m_paddr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign to_flag = st_q.flag;
    assign to_addr = st_q.addr;

endmodule

// File: rtl/apb_guard_checker.sv
`timescale 1ns/1ps
module apb_guard_checker
    import apb_guard_pkg::*;
#(
    parameter int NS = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_psel,
    input logic          m_penable,
    input logic          m_pready,
    input logic          m_pslverr,
    input logic [DW-1:0] m_prdata,
    input logic [NS-1:0] s_psel,
    input dec_class_e    cls,
    input logic          fire,
    input logic [CW-1:0] cnt,
    input logic          to_clear,
    input logic          to_flag,
    input logic [AW-1:0] to_addr
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_psel)); // R1

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !m_psel |-> (m_pready && !m_pslverr && m_prdata == '0)); // R3

    AST_ERR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (m_psel && m_penable && is_err_region(cls))
        |-> (m_pready && m_pslverr && s_psel == '0 && m_prdata == '0)); // R4 R5

    AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (m_pready && m_pslverr && m_prdata == '0)); // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_psel && m_penable) |=> (cnt == '0)); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> to_flag); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !to_clear) |=> to_flag); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clear && !fire) |=> (!to_flag && to_addr == '0)); // R9

    AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !to_clear) |=> $stable(to_addr)); // R10

endmodule

bind apb_guard_bridge apb_guard_checker #(
    .NS (NS),
    .AW (AW),
    .DW (DW),
    .CW (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_psel    (m_psel),
    .m_penable (m_penable),
    .m_pready  (m_pready),
    .m_pslverr (m_pslverr),
    .m_prdata  (m_prdata),
    .s_psel    (s_psel),
    .cls       (dec_cls),
    .fire      (wd_fire),
    .cnt       (wd_cnt),
    .to_clear  (to_clear),
    .to_flag   (to_flag),
    .to_addr   (to_addr)
);

// File: tb/apb_guard_bridge_bench.sv
`timescale 1ns/1ps
module apb_guard_bridge_bench;

    localparam int NS    = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int RB    = 12;
    localparam int LIMIT = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             m_psel = 1'b0;
    logic             m_penable = 1'b0;
    logic             m_pwrite = 1'b0;
    logic [AW-1:0]    m_paddr = '0;
    logic [DW-1:0]    m_pwdata = '0;
    logic [DW-1:0]    m_prdata;
    logic             m_pready;
    logic             m_pslverr;
    logic [NS-1:0]    s_psel;
    logic             s_penable;
    logic             s_pwrite;
    logic [AW-1:0]    s_paddr;
    logic [DW-1:0]    s_pwdata;
    logic [NS*DW-1:0] s_prdata;
    logic [NS-1:0]    s_pready;
    logic [NS-1:0]    s_pslverr;
    logic [NS-1:0]    s_clk_on = '1;
    logic             to_clear = 1'b0;
    logic             to_flag;
    logic [AW-1:0]    to_addr;

    always #2 clk = ~clk;   // 250 MHz

    apb_guard_bridge #(
        .NS(NS), .AW(AW), .DW(DW), .RB(RB), .LIMIT(LIMIT)
    ) u_apb_guard_bridge (
        .clk(clk), .rst_n(rst_n),
        .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_paddr(m_paddr), .m_pwdata(m_pwdata),
        .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr),
        .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
        .s_paddr(s_paddr), .s_pwdata(s_pwdata),
        .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr),
        .s_clk_on(s_clk_on),
        .to_clear(to_clear), .to_flag(to_flag), .to_addr(to_addr)
    );

    // Subordinate models: wait count per port, -1 = never ready
    int            wcfg [NS];
    int            wcnt [NS];
    logic [NS-1:0] errcfg = '0;

    generate
        for (genvar i = 0; i < NS; i++) begin : g_sub
            assign s_pready[i]  = (wcfg[i] >= 0) && (wcnt[i] >= wcfg[i]);
            assign s_pslverr[i] = errcfg[i];
            assign s_prdata[i*DW +: DW] = 32'hA000_0000 | (32'(i) << 16) | {20'h0, s_paddr[11:0]};
            always @(posedge clk) begin
                if (s_psel[i] && s_penable && !s_pready[i]) wcnt[i] <= wcnt[i] + 1;
                else wcnt[i] <= 0;
            end
        end
    endgenerate

    function automatic logic [31:0] sub_data(int i, logic [AW-1:0] a);
        return 32'hA000_0000 | (32'(i) << 16) | {20'h0, a[11:0]};
    endfunction

    // Scoreboard
    typedef struct {
        logic [31:0]   rdata;
        logic          err;
        int            waits;
        logic [NS-1:0] sel;
        string         tag;
    } exp_t;

    exp_t exp_q [$];
    int   checks = 0;
    int   fails  = 0;
    int   mon_waits = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: sample between edges
    always @(negedge clk) begin
        if (rst_n && m_psel && m_penable) begin
            if (m_pready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected completion", 64'(m_prdata), 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_prdata == e.rdata, e.tag, "rdata", 64'(m_prdata), 64'(e.rdata));
                    chk(m_pslverr == e.err, e.tag, "pslverr", 64'(m_pslverr), 64'(e.err));
                    chk(mon_waits == e.waits, e.tag, "wait cycles", 64'(mon_waits), 64'(e.waits));
                    chk(s_psel == e.sel, e.tag, "s_psel", 64'(s_psel), 64'(e.sel));
                end
                mon_waits = 0;
            end else begin
                mon_waits++;
            end
        end
    end

    // Driver
    task automatic xfer(logic [AW-1:0] a, logic wr, logic [DW-1:0] wd,
                        logic [31:0] erd, logic eerr, int ew, logic [NS-1:0] esel,
                        string tag, bit clr_at_fire);
        exp_t e;
        e.rdata = erd; e.err = eerr; e.waits = ew; e.sel = esel; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
        m_psel = 1'b1; m_penable = 1'b0; m_pwrite = wr; m_paddr = a; m_pwdata = wd;
        @(negedge clk);
        // R1: request fields forwarded unchanged
        chk(s_paddr == a && s_pwdata == wd && s_pwrite == wr, "R1", "forwarded request",
            64'(s_paddr), 64'(a));
        @(posedge clk); #1;
        m_penable = 1'b1;
        forever begin
            @(negedge clk);
            if (m_pready) break;
        end
        if (clr_at_fire) to_clear = 1'b1;
        @(posedge clk); #1;
        m_psel = 1'b0; m_penable = 1'b0; to_clear = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        chk(1'b0, "R6", "watchdog expired", 64'h0, 64'h1);
        report();
    end

    initial begin
        wcfg[0] = 0; wcfg[1] = 3; wcfg[2] = 15; wcfg[3] = -1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3, R9)
        chk(m_pready == 1'b1 && m_pslverr == 1'b0, "R3", "idle ready", 64'(m_pready), 64'h1);
        chk(s_psel == '0, "R1", "idle select", 64'(s_psel), 64'h0);
        chk(to_flag == 1'b0 && to_addr == '0, "R9", "reset sticky", 64'(to_addr), 64'h0);

        // R2: zero-wait read from port 0 (port 3 is holding ready low: R3)
        xfer(16'h0124, 1'b0, '0, sub_data(0, 16'h0124), 1'b0, 0, 4'b0001, "R2", 1'b0);
        // R2: three waits with subordinate error on a write
        errcfg[1] = 1'b1;
        xfer(16'h1A08, 1'b1, 32'h1234_5678, sub_data(1, 16'h1A08), 1'b1, 3, 4'b0010, "R2", 1'b0);
        errcfg[1] = 1'b0;
        // R7: ready on the very cycle the watchdog would fire -> normal
        xfer(16'h2040, 1'b0, '0, sub_data(2, 16'h2040), 1'b0, LIMIT - 1, 4'b0100, "R7", 1'b0);
        chk(to_flag == 1'b0, "R7", "no sticky on late-but-ready", 64'(to_flag), 64'h0);
        // R4: unmapped index 5
        xfer(16'h5123, 1'b0, '0, 32'h0, 1'b1, 0, 4'b0000, "R4", 1'b0);
        // R5: port 2 clock gated
        s_clk_on[2] = 1'b0;
        xfer(16'h2010, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b1, 0, 4'b0000, "R5", 1'b0);
        s_clk_on[2] = 1'b1;
        // R6: never-ready port 3
        xfer(16'h3ABC, 1'b0, '0, 32'h0, 1'b1, LIMIT - 1, 4'b1000, "R6", 1'b0);
        chk(to_flag == 1'b1, "R9", "flag after abort", 64'(to_flag), 64'h1);
        chk(to_addr == 16'h3ABC, "R9", "captured addr", 64'(to_addr), 64'h3ABC);
        // R8: next access proceeds normally
        xfer(16'h0300, 1'b0, '0, sub_data(0, 16'h0300), 1'b0, 0, 4'b0001, "R8", 1'b0);
        // R3: idle with port 3 ready low -> manager still sees ready
        @(negedge clk);
        chk(m_pready == 1'b1, "R3", "idle ready with stuck port", 64'(m_pready), 64'h1);
        // R10: second abort does not overwrite the captured address
        xfer(16'h3DEF, 1'b1, 32'h1, 32'h0, 1'b1, LIMIT - 1, 4'b1000, "R6", 1'b0);
        chk(to_addr == 16'h3ABC, "R10", "addr kept", 64'(to_addr), 64'h3ABC);
        // R9: clear alone
        @(posedge clk); #1 to_clear = 1'b1;
        @(posedge clk); #1 to_clear = 1'b0;
        @(negedge clk);
        chk(to_flag == 1'b0 && to_addr == '0, "R9", "cleared", 64'(to_addr), 64'h0);
        // R9: set again, then abort and clear in the same cycle
        xfer(16'h3222, 1'b0, '0, 32'h0, 1'b1, LIMIT - 1, 4'b1000, "R6", 1'b0);
        chk(to_addr == 16'h3222, "R9", "capture after clear", 64'(to_addr), 64'h3222);
        xfer(16'h3333, 1'b0, '0, 32'h0, 1'b1, LIMIT - 1, 4'b1000, "R9", 1'b1);
        chk(to_flag == 1'b1, "R9", "set wins over clear", 64'(to_flag), 64'h1);
        chk(to_addr == 16'h3333, "R9", "addr of colliding abort", 64'(to_addr), 64'h3333);
        // R8: after abort, a waiting access still completes normally
        xfer(16'h1004, 1'b0, '0, sub_data(1, 16'h1004), 1'b0, 3, 4'b0010, "R8", 1'b0);

        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", 64'(exp_q.size()), 64'h0);
        report();
    end

endmodule